// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block holds a small set of virtual-to-physical page mappings and compares all of them in parallel against a requested virtual page number. Each slot stores a valid bit, the virtual page tag, the address-space number of its owner, a global flag, a physical page number, a read-enable mask and a write-enable mask with one bit per privilege mode, and two fault-on-access bits, one for reads and one for writes. A slot matches when it is valid and its tag is equal to the request. Its address-space number must also equal the current one, unless the slot is global, in which case the address-space number is ignored. The lookup is combinational. It returns a hit flag, the index of the matching slot and that slot's fields.

New mappings go into the slot named by a round-robin victim pointer, which then moves on. Three kinds of invalidation are available. A full flush empties the whole array and returns the pointer to slot 0. A process flush removes every mapping that is not global. An address flush removes exactly the mappings that a lookup of a given page and address-space number would hit. The slot under the victim pointer is always visible on a second read port, and a step input moves the pointer without writing anything. This lets maintenance code inspect the slots one after another. Page-table walking and fault generation are left to the surrounding logic. The default depth is 48 slots, which suits an instruction-side instance. A data-side instance sets the depth to 64.

Top module: `tlb_asn_fa`

## Requirements
- R1: A lookup hits only when some slot is valid, its tag equals `lk_vpn`, and its global flag is 1 or its stored address-space number equals `lk_asn`. On a miss, `lk_hit`, `lk_idx`, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_flt_rd` and `lk_flt_wr` are all 0.
- R2: When several slots hit, `lk_idx` and the lookup fields come from the lowest-numbered one.
- R3: An accepted insert writes all given fields into the slot at `vic_ptr`, sets its valid bit, and advances `vic_ptr` by one at the same clock edge.
- R4: `vic_ptr` steps from DEPTH-1 back to 0. After DEPTH accepted inserts that start from slot 0, the pointer is 0 again.
- R5: `flush_all` clears every slot and sets `vic_ptr` to 0 at the next edge, whatever other inputs are active.
- R6: `flush_proc` invalidates every slot whose global flag is 0 and leaves global slots valid and unchanged.
- R7: `flush_addr` invalidates every slot that a lookup with `fa_vpn`/`fa_asn` would hit, global slots included, and leaves all other slots alone.
- R8: The `vic_*` outputs show the slot at `vic_ptr`. `vic_adv` advances the pointer by one without writing a slot. With neither `vic_adv` nor an accepted insert, the pointer holds. When `vic_adv` and an accepted insert arrive in the same cycle, the pointer advances only once.
- R9: An insert in a cycle where any flush input is 1 is dropped. No slot is written, and the insert does not advance the pointer.
- R10: While `rst_n` is low at a clock edge, all slots become invalid and `vic_ptr` becomes 0. Reset is synchronous and active low.
- R11: The lookup reflects slot contents as registered before the current edge. An insert becomes visible to lookups in the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_idx | output | PTR_W | Index of the lowest matching slot |
| lk_ppn | output | PPN_W | Physical page of the match |
| lk_rd_en | output | NMODES | Read-enable mask per mode of the match |
| lk_wr_en | output | NMODES | Write-enable mask per mode of the match |
| lk_flt_rd | output | 1 | Fault-on-read bit of the match |
| lk_flt_wr | output | 1 | Fault-on-write bit of the match |
| ins_en | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Tag to insert |
| ins_asn | input | ASN_W | Address-space number to insert |
| ins_glob | input | 1 | Global flag to insert |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_rd_en | input | NMODES | Read-enable mask to insert |
| ins_wr_en | input | NMODES | Write-enable mask to insert |
| ins_flt_rd | input | 1 | Fault-on-read bit to insert |
| ins_flt_wr | input | 1 | Fault-on-write bit to insert |
| flush_all | input | 1 | Clear all slots, pointer to 0 |
| flush_proc | input | 1 | Invalidate non-global slots |
| flush_addr | input | 1 | Invalidate slots matching fa_vpn/fa_asn |
| fa_vpn | input | VPN_W | Page number for the address flush |
| fa_asn | input | ASN_W | Address-space number for the address flush |
| vic_adv | input | 1 | Step the victim pointer |
| vic_ptr | output | PTR_W | Current victim pointer |
| vic_valid | output | 1 | Valid bit of the slot at the pointer |
| vic_vpn | output | VPN_W | Tag of the slot at the pointer |
| vic_asn | output | ASN_W | Address-space number of the slot at the pointer |
| vic_glob | output | 1 | Global flag of the slot at the pointer |
| vic_ppn | output | PPN_W | Physical page of the slot at the pointer |
| vic_rd_en | output | NMODES | Read-enable mask of the slot at the pointer |
| vic_wr_en | output | NMODES | Write-enable mask of the slot at the pointer |
| vic_flt_rd | output | 1 | Fault-on-read bit of the slot at the pointer |
| vic_flt_wr | output | 1 | Fault-on-write bit of the slot at the pointer |

## Verification
The assertions assume that control inputs are known (never X) once reset is released. They make no assumption about duplicate tags, since repeated tags are legal and resolved by the lowest index. They also assume that flushes may coincide with inserts and pointer steps in any combination. The stimulus uses a four-bit page space and a two-bit address-space space, so duplicate and global matches occur often. It freely overlaps inserts with all three flush kinds and with pointer steps. Directed sequences cover the pointer wrap, a flush that collides with an insert, and an address flush that removes a global slot.

// File: rtl/tlb_asn_pkg.sv
// Package tlb_asn_pkg
// Shared action encoding and slot-index arithmetic for the translation
// buffer. Assumes depths fit in 32 bits.
package tlb_asn_pkg;

    // Resolved write action for one cycle; flushes outrank inserts.
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_INSERT = 2'd1,
        ACT_FLUSH  = 2'd2
    } tlb_act_e;

    // Next round-robin slot, wrapping at depth.
    function automatic int unsigned next_slot(input int unsigned cur,
                                              input int unsigned depth);
        return (cur + 1 >= depth) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/tlb_low_pick.sv
// Module tlb_low_pick
// Lowest-index priority picker over a request vector. Produces a found
// flag and the index of the lowest set bit (0 when none is set).
// Clock and reset are used only by the embedded check.
module tlb_low_pick #(
    parameter int N = 48,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);

    // Scan from the top so the lowest set bit is the last to assign.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end

    logic [N-1:0] below_mask;

    // Mask of all positions beneath the picked index, for the check only.
    always_comb begin
        below_mask = '0;
        for (int i = 0; i < N; i++) begin
            if (W'(i) < idx) below_mask[i] = 1'b1;
        end
    end

    // R2
    lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (req[idx] && ((req & below_mask) == '0)));

endmodule

// File: rtl/tlb_victim_ctr.sv
// Module tlb_victim_ctr
// Round-robin victim pointer. Clears to slot 0 on reset or a full flush,
// otherwise advances one slot per cycle in which step is high, wrapping
// from DEPTH-1 to 0. Assumes step and clr are never X after reset.
module tlb_victim_ctr
    import tlb_asn_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;

    // Hold, clear or advance the pointer each edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= PTR_W'(next_slot(int'(ptr_q), DEPTH));
        end
    end

    assign ptr = ptr_q;

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step && ptr_q == LAST) |=> (ptr_q == '0));

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(ptr_q));

    // R5
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr_q == '0));

endmodule

// File: rtl/tlb_asn_store.sv
// Module tlb_asn_store
// Slot storage with per-slot comparators. Two match vectors are produced:
// one for the lookup request and one for the address flush. Both follow
// the same rule (valid, equal tag, global or equal space number). Writes
// are decided by the caller: wr_en is already qualified against flushes.
// Two read ports expose the fields of any slot by index.
module tlb_asn_store #(
    parameter int DEPTH  = 48,
    parameter int VPN_W  = 28,
    parameter int ASN_W  = 8,
    parameter int PPN_W  = 28,
    parameter int NMODES = 4,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup compare
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic [DEPTH-1:0]  lk_vec,
    // invalidation controls
    input  logic              clr_all,
    input  logic              clr_proc,
    input  logic              clr_addr,
    input  logic [VPN_W-1:0]  fa_vpn,
    input  logic [ASN_W-1:0]  fa_asn,
    // slot write
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASN_W-1:0]  wr_asn,
    input  logic              wr_glob,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [NMODES-1:0] wr_rd_en,
    input  logic [NMODES-1:0] wr_wr_en,
    input  logic              wr_flt_rd,
    input  logic              wr_flt_wr,
    // read port A
    input  logic [PTR_W-1:0]  a_idx,
    output logic [PPN_W-1:0]  a_ppn,
    output logic [NMODES-1:0] a_rd_en,
    output logic [NMODES-1:0] a_wr_en,
    output logic              a_flt_rd,
    output logic              a_flt_wr,
    // read port B
    input  logic [PTR_W-1:0]  b_idx,
    output logic              b_valid,
    output logic [VPN_W-1:0]  b_vpn,
    output logic [ASN_W-1:0]  b_asn,
    output logic              b_glob,
    output logic [PPN_W-1:0]  b_ppn,
    output logic [NMODES-1:0] b_rd_en,
    output logic [NMODES-1:0] b_wr_en,
    output logic              b_flt_rd,
    output logic              b_flt_wr
);

    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  glob_q;
    logic [DEPTH-1:0]  frd_q;
    logic [DEPTH-1:0]  fwr_q;
    logic [VPN_W-1:0]  vpn_q  [DEPTH];
    logic [ASN_W-1:0]  asn_q  [DEPTH];
    logic [PPN_W-1:0]  ppn_q  [DEPTH];
    logic [NMODES-1:0] rde_q  [DEPTH];
    logic [NMODES-1:0] wre_q  [DEPTH];
    logic [DEPTH-1:0]  fa_vec;

    // Per-slot comparators for lookup and address flush.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign lk_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn) &&
                           (glob_q[g] || (asn_q[g] == lk_asn));
        assign fa_vec[g] = valid_q[g] && (vpn_q[g] == fa_vpn) &&
                           (glob_q[g] || (asn_q[g] == fa_asn));
    end

    // Slot update: reset or full flush wipes, else invalidate and write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            valid_q <= '0;
            glob_q  <= '0;
            frd_q   <= '0;
            fwr_q   <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                vpn_q[i] <= '0;
                asn_q[i] <= '0;
                ppn_q[i] <= '0;
                rde_q[i] <= '0;
                wre_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((clr_proc && !glob_q[i]) || (clr_addr && fa_vec[i])) begin
                    valid_q[i] <= 1'b0;
                end
                if (wr_en && (wr_idx == PTR_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    vpn_q[i]   <= wr_vpn;
                    asn_q[i]   <= wr_asn;
                    glob_q[i]  <= wr_glob;
                    ppn_q[i]   <= wr_ppn;
                    rde_q[i]   <= wr_rd_en;
                    wre_q[i]   <= wr_wr_en;
                    frd_q[i]   <= wr_flt_rd;
                    fwr_q[i]   <= wr_flt_wr;
                end
            end
        end
    end

    // Read port A: fields of the picked lookup slot.
    always_comb begin
        a_ppn    = ppn_q[a_idx];
        a_rd_en  = rde_q[a_idx];
        a_wr_en  = wre_q[a_idx];
        a_flt_rd = frd_q[a_idx];
        a_flt_wr = fwr_q[a_idx];
    end

    // Read port B: full slot under the victim pointer.
    always_comb begin
        b_valid  = valid_q[b_idx];
        b_vpn    = vpn_q[b_idx];
        b_asn    = asn_q[b_idx];
        b_glob   = glob_q[b_idx];
        b_ppn    = ppn_q[b_idx];
        b_rd_en  = rde_q[b_idx];
        b_wr_en  = wre_q[b_idx];
        b_flt_rd = frd_q[b_idx];
        b_flt_wr = fwr_q[b_idx];
    end

    // R3
    insert_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all) |=> (valid_q[$past(wr_idx)] &&
                                 vpn_q[$past(wr_idx)] == $past(wr_vpn) &&
                                 ppn_q[$past(wr_idx)] == $past(wr_ppn)));

    // R5
    flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_q == '0));

    // R6
    proc_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_proc && !wr_en) |=> ((valid_q & ~glob_q) == '0));

    // R6
    proc_keeps_glob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_proc && !clr_all && !clr_addr && !wr_en) |=>
            ((valid_q & glob_q) == $past(valid_q & glob_q)));

    // R7
    addr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_addr && !wr_en) |=> ((valid_q & $past(fa_vec)) == '0));

endmodule

// File: rtl/tlb_asn_fa.sv
// Module tlb_asn_fa
// Fully associative translation buffer tagged by address-space number.
// Combinational lookup with lowest-index priority, round-robin insert,
// full / non-global / by-address invalidation, and a victim-slot read
// port with an optional pointer step. Any flush suppresses a same-cycle
// insert. Assumes control inputs are known once reset is released.
module tlb_asn_fa
    import tlb_asn_pkg::*;
#(
    parameter int DEPTH  = 48,
    parameter int VPN_W  = 28,
    parameter int ASN_W  = 8,
    parameter int PPN_W  = 28,
    parameter int NMODES = 4,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [PTR_W-1:0]  lk_idx,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [NMODES-1:0] lk_rd_en,
    output logic [NMODES-1:0] lk_wr_en,
    output logic              lk_flt_rd,
    output logic              lk_flt_wr,
    input  logic              ins_en,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic              ins_glob,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [NMODES-1:0] ins_rd_en,
    input  logic [NMODES-1:0] ins_wr_en,
    input  logic              ins_flt_rd,
    input  logic              ins_flt_wr,
    input  logic              flush_all,
    input  logic              flush_proc,
    input  logic              flush_addr,
    input  logic [VPN_W-1:0]  fa_vpn,
    input  logic [ASN_W-1:0]  fa_asn,
    input  logic              vic_adv,
    output logic [PTR_W-1:0]  vic_ptr,
    output logic              vic_valid,
    output logic [VPN_W-1:0]  vic_vpn,
    output logic [ASN_W-1:0]  vic_asn,
    output logic              vic_glob,
    output logic [PPN_W-1:0]  vic_ppn,
    output logic [NMODES-1:0] vic_rd_en,
    output logic [NMODES-1:0] vic_wr_en,
    output logic              vic_flt_rd,
    output logic              vic_flt_wr
);

    tlb_act_e          act;
    logic              do_insert;
    logic [DEPTH-1:0]  lk_vec;
    logic              pick_found;
    logic [PTR_W-1:0]  pick_idx;
    logic [PPN_W-1:0]  a_ppn;
    logic [NMODES-1:0] a_rd_en;
    logic [NMODES-1:0] a_wr_en;
    logic              a_flt_rd;
    logic              a_flt_wr;
    logic [PTR_W-1:0]  ptr;

    // Resolve this cycle's write action; flush beats insert.
    always_comb begin
        if (flush_all || flush_proc || flush_addr) act = ACT_FLUSH;
        else if (ins_en)                            act = ACT_INSERT;
        else                                        act = ACT_IDLE;
    end

    assign do_insert = (act == ACT_INSERT);

    tlb_asn_store #(
        .DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W),
        .PPN_W(PPN_W), .NMODES(NMODES), .PTR_W(PTR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (lk_vpn),
        .lk_asn    (lk_asn),
        .lk_vec    (lk_vec),
        .clr_all   (flush_all),
        .clr_proc  (flush_proc),
        .clr_addr  (flush_addr),
        .fa_vpn    (fa_vpn),
        .fa_asn    (fa_asn),
        .wr_en     (do_insert),
        .wr_idx    (ptr),
        .wr_vpn    (ins_vpn),
        .wr_asn    (ins_asn),
        .wr_glob   (ins_glob),
        .wr_ppn    (ins_ppn),
        .wr_rd_en  (ins_rd_en),
        .wr_wr_en  (ins_wr_en),
        .wr_flt_rd (ins_flt_rd),
        .wr_flt_wr (ins_flt_wr),
        .a_idx     (pick_idx),
        .a_ppn     (a_ppn),
        .a_rd_en   (a_rd_en),
        .a_wr_en   (a_wr_en),
        .a_flt_rd  (a_flt_rd),
        .a_flt_wr  (a_flt_wr),
        .b_idx     (ptr),
        .b_valid   (vic_valid),
        .b_vpn     (vic_vpn),
        .b_asn     (vic_asn),
        .b_glob    (vic_glob),
        .b_ppn     (vic_ppn),
        .b_rd_en   (vic_rd_en),
        .b_wr_en   (vic_wr_en),
        .b_flt_rd  (vic_flt_rd),
        .b_flt_wr  (vic_flt_wr)
    );

    tlb_low_pick #(.N(DEPTH), .W(PTR_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (lk_vec),
        .found (pick_found),
        .idx   (pick_idx)
    );

    tlb_victim_ctr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_vic (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_all),
        .step  (do_insert || vic_adv),
        .ptr   (ptr)
    );

    // Drive lookup results, forced to zero on a miss.
    always_comb begin
        lk_hit    = pick_found;
        lk_idx    = pick_found ? pick_idx : '0;
        lk_ppn    = pick_found ? a_ppn    : '0;
        lk_rd_en  = pick_found ? a_rd_en  : '0;
        lk_wr_en  = pick_found ? a_wr_en  : '0;
        lk_flt_rd = pick_found && a_flt_rd;
        lk_flt_wr = pick_found && a_flt_wr;
    end

    assign vic_ptr = ptr;

    // R9
    flush_drops_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flush_proc || flush_addr) && !flush_all && ins_en && !vic_adv)
            |=> $stable(vic_ptr));

    // R3
    insert_steps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !flush_all && !flush_proc && !flush_addr &&
         vic_ptr != PTR_W'(DEPTH - 1)) |=> (vic_ptr == $past(vic_ptr) + 1'b1));

    // R1
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0 && lk_idx == '0 && !lk_flt_rd && !lk_flt_wr));

endmodule

// File: tb/tb_tlb_asn_fa.sv
`timescale 1ns/1ps
module tb_tlb_asn_fa;

    localparam int DEPTH  = 48;
    localparam int VPN_W  = 4;
    localparam int ASN_W  = 2;
    localparam int PPN_W  = 8;
    localparam int NMODES = 4;
    localparam int PTR_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [VPN_W-1:0]  lk_vpn;
    logic [ASN_W-1:0]  lk_asn;
    logic              lk_hit;
    logic [PTR_W-1:0]  lk_idx;
    logic [PPN_W-1:0]  lk_ppn;
    logic [NMODES-1:0] lk_rd_en, lk_wr_en;
    logic              lk_flt_rd, lk_flt_wr;
    logic              ins_en;
    logic [VPN_W-1:0]  ins_vpn;
    logic [ASN_W-1:0]  ins_asn;
    logic              ins_glob;
    logic [PPN_W-1:0]  ins_ppn;
    logic [NMODES-1:0] ins_rd_en, ins_wr_en;
    logic              ins_flt_rd, ins_flt_wr;
    logic              flush_all, flush_proc, flush_addr;
    logic [VPN_W-1:0]  fa_vpn;
    logic [ASN_W-1:0]  fa_asn;
    logic              vic_adv;
    logic [PTR_W-1:0]  vic_ptr;
    logic              vic_valid;
    logic [VPN_W-1:0]  vic_vpn;
    logic [ASN_W-1:0]  vic_asn;
    logic              vic_glob;
    logic [PPN_W-1:0]  vic_ppn;
    logic [NMODES-1:0] vic_rd_en, vic_wr_en;
    logic              vic_flt_rd, vic_flt_wr;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    tlb_asn_fa #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W),
                 .PPN_W(PPN_W), .NMODES(NMODES), .PTR_W(PTR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
        .lk_flt_rd(lk_flt_rd), .lk_flt_wr(lk_flt_wr),
        .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_asn(ins_asn),
        .ins_glob(ins_glob), .ins_ppn(ins_ppn), .ins_rd_en(ins_rd_en),
        .ins_wr_en(ins_wr_en), .ins_flt_rd(ins_flt_rd), .ins_flt_wr(ins_flt_wr),
        .flush_all(flush_all), .flush_proc(flush_proc), .flush_addr(flush_addr),
        .fa_vpn(fa_vpn), .fa_asn(fa_asn), .vic_adv(vic_adv),
        .vic_ptr(vic_ptr), .vic_valid(vic_valid), .vic_vpn(vic_vpn),
        .vic_asn(vic_asn), .vic_glob(vic_glob), .vic_ppn(vic_ppn),
        .vic_rd_en(vic_rd_en), .vic_wr_en(vic_wr_en),
        .vic_flt_rd(vic_flt_rd), .vic_flt_wr(vic_flt_wr)
    );

    // reference model
    bit             m_v   [DEPTH];
    bit [VPN_W-1:0] m_vpn [DEPTH];
    bit [ASN_W-1:0] m_asn [DEPTH];
    bit             m_g   [DEPTH];
    bit [PPN_W-1:0] m_ppn [DEPTH];
    bit [3:0]       m_rde [DEPTH];
    bit [3:0]       m_wre [DEPTH];
    bit             m_fr  [DEPTH];
    bit             m_fw  [DEPTH];
    int             m_ptr;

    function automatic bit m_match(int i, bit [VPN_W-1:0] v, bit [ASN_W-1:0] a);
        return m_v[i] && m_vpn[i] == v && (m_g[i] || m_asn[i] == a);
    endfunction

    function automatic int m_first(bit [VPN_W-1:0] v, bit [ASN_W-1:0] a);
        for (int i = 0; i < DEPTH; i++) if (m_match(i, v, a)) return i;
        return -1;
    endfunction

    function automatic int m_count(bit [VPN_W-1:0] v, bit [ASN_W-1:0] a);
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (m_match(i, v, a)) n++;
        return n;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 0; m_vpn[i] = 0; m_asn[i] = 0; m_g[i] = 0; m_ppn[i] = 0;
            m_rde[i] = 0; m_wre[i] = 0; m_fr[i] = 0; m_fw[i] = 0;
        end
        m_ptr = 0;
    endtask

    task automatic check(string tag, longint got, longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic idle();
        ins_en = 0; ins_vpn = 0; ins_asn = 0; ins_glob = 0; ins_ppn = 0;
        ins_rd_en = 0; ins_wr_en = 0; ins_flt_rd = 0; ins_flt_wr = 0;
        flush_all = 0; flush_proc = 0; flush_addr = 0; fa_vpn = 0; fa_asn = 0;
        vic_adv = 0;
    endtask

    // Compare all outputs with the model state, then clock and update it.
    task automatic tick();
        int f, n;
        bit insert_ok;
        bit [VPN_W-1:0] fv;
        bit [ASN_W-1:0] fa;
        bit fm [DEPTH];
        string tg;
        f = m_first(lk_vpn, lk_asn);
        n = m_count(lk_vpn, lk_asn);
        tg = (n > 1) ? "R2" : "R1";
        check(tg, lk_hit, f >= 0);
        check(tg, lk_idx, f >= 0 ? f : 0);
        check(tg, lk_ppn, f >= 0 ? m_ppn[f] : 0);
        check(tg, lk_rd_en, f >= 0 ? m_rde[f] : 0);
        check(tg, lk_wr_en, f >= 0 ? m_wre[f] : 0);
        check(tg, {lk_flt_rd, lk_flt_wr}, f >= 0 ? {m_fr[f], m_fw[f]} : 0);
        check("R8", vic_ptr, m_ptr);
        check("R8", vic_valid, m_v[m_ptr]);
        check("R8", {vic_vpn, vic_asn, vic_glob, vic_ppn},
              {m_vpn[m_ptr], m_asn[m_ptr], m_g[m_ptr], m_ppn[m_ptr]});
        check("R8", {vic_rd_en, vic_wr_en, vic_flt_rd, vic_flt_wr},
              {m_rde[m_ptr], m_wre[m_ptr], m_fr[m_ptr], m_fw[m_ptr]});
        @(posedge clk);
        fv = fa_vpn; fa = fa_asn;
        if (!rst_n || flush_all) begin
            m_clear();
        end else begin
            for (int i = 0; i < DEPTH; i++) fm[i] = m_match(i, fv, fa);
            for (int i = 0; i < DEPTH; i++) begin
                if (flush_proc && !m_g[i]) m_v[i] = 0;
                if (flush_addr && fm[i])   m_v[i] = 0;
            end
            insert_ok = ins_en && !flush_proc && !flush_addr;
            if (insert_ok) begin
                m_v[m_ptr] = 1; m_vpn[m_ptr] = ins_vpn; m_asn[m_ptr] = ins_asn;
                m_g[m_ptr] = ins_glob; m_ppn[m_ptr] = ins_ppn;
                m_rde[m_ptr] = ins_rd_en; m_wre[m_ptr] = ins_wr_en;
                m_fr[m_ptr] = ins_flt_rd; m_fw[m_ptr] = ins_flt_wr;
            end
            if (insert_ok || vic_adv) m_ptr = (m_ptr + 1 >= DEPTH) ? 0 : m_ptr + 1;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic put(int v, int a, bit g, int p);
        ins_en = 1; ins_vpn = VPN_W'(v); ins_asn = ASN_W'(a); ins_glob = g;
        ins_ppn = PPN_W'(p); ins_rd_en = 4'h5; ins_wr_en = 4'h3;
        ins_flt_rd = 0; ins_flt_wr = 1;
    endtask

    task automatic look(int v, int a);
        lk_vpn = VPN_W'(v); lk_asn = ASN_W'(a);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234abcd));
        idle(); look(0, 0); m_clear();
        rst_n = 0;
        @(negedge clk); tick(); tick(); tick();
        rst_n = 1;
        #1;
        // R10 reset state
        check("R10", vic_ptr, 0);
        check("R10", vic_valid, 0);
        check("R10", lk_hit, 0);
        tick();

        // R11: insert and same-cycle lookup of its page misses
        put(3, 1, 0, 8'h11); look(3, 1); #1;
        check("R11", lk_hit, 0);
        tick();
        look(3, 1); #1;
        check("R11", lk_hit, 1);
        check("R3", lk_ppn, 8'h11);
        check("R3", vic_ptr, 1);
        check("R3", lk_flt_wr, 1);
        look(3, 2); #1;
        check("R1", lk_hit, 0);
        tick();

        // global slot ignores the space number
        put(5, 0, 1, 8'h22); tick();
        look(5, 3); #1;
        check("R1", lk_hit, 1);
        check("R1", lk_idx, 1);
        tick();

        // duplicate tag: lowest index wins
        put(3, 1, 0, 8'h33); tick();
        look(3, 1); #1;
        check("R2", lk_idx, 0);
        check("R2", lk_ppn, 8'h11);
        tick();

        // pointer step without writing
        vic_adv = 1; tick();
        #1; check("R8", vic_ptr, 4); check("R8", vic_valid, 0);
        tick();
        #1; check("R8", vic_ptr, 4);
        // insert plus step moves once
        put(9, 0, 0, 8'h44); vic_adv = 1; tick();
        #1; check("R8", vic_ptr, 5);

        // address flush removes both copies of page 3 space 1
        flush_addr = 1; fa_vpn = 3; fa_asn = 1; tick();
        look(3, 1); #1; check("R7", lk_hit, 0);
        look(5, 2); #1; check("R7", lk_hit, 1);
        look(9, 0); #1; check("R7", lk_hit, 1);
        tick();

        // process flush with colliding insert
        flush_proc = 1; put(12, 2, 0, 8'h55); tick();
        #1; check("R9", vic_ptr, 5);
        look(12, 2); #1; check("R9", lk_hit, 0);
        look(9, 0);  #1; check("R6", lk_hit, 0);
        look(5, 1);  #1; check("R6", lk_hit, 1);
        tick();

        // address flush also removes a global slot
        flush_addr = 1; fa_vpn = 5; fa_asn = 2; tick();
        look(5, 0); #1; check("R7", lk_hit, 0);
        tick();

        // full flush with an insert: dropped, pointer to zero
        put(1, 1, 0, 8'h66); tick();
        flush_all = 1; put(2, 2, 0, 8'h77); vic_adv = 1; tick();
        #1; check("R5", vic_ptr, 0);
        look(1, 1); #1; check("R5", lk_hit, 0);
        look(2, 2); #1; check("R9", lk_hit, 0);
        tick();

        // fill every slot: pointer wraps to zero
        for (int k = 0; k < DEPTH; k++) begin
            put(k % 16, k % 4, 0, k); tick();
        end
        #1;
        check("R4", vic_ptr, 0);
        check("R4", vic_valid, 1);
        check("R4", vic_ppn, 0);
        look(15, 3); #1; check("R4", lk_idx, 15);
        tick();

        // constrained random mix
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = $urandom % 100;
            look($urandom % 16, $urandom % 4);
            if (r < 45) begin
                put($urandom % 16, $urandom % 4, ($urandom % 4) == 0, $urandom % 256);
                ins_rd_en = 4'($urandom); ins_wr_en = 4'($urandom);
                ins_flt_rd = 1'($urandom); ins_flt_wr = 1'($urandom);
            end
            r = $urandom % 100;
            if (r < 2)       flush_all  = 1;
            else if (r < 6)  flush_proc = 1;
            else if (r < 14) begin
                flush_addr = 1; fa_vpn = 4'($urandom); fa_asn = 2'($urandom);
            end
            if (($urandom % 5) == 0) vic_adv = 1;
            #1;
            tick();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule